// File: doc/BRIEF.md
# Datapath Stall Watchdog

The block supervises four data-moving engines of an Ethernet controller: the transmit DMA, the transmit MAC, the receive DMA and the receive MAC. Each engine reports a busy level and a one-cycle progress strobe. When an enabled engine stays busy with no progress strobe for longer than a programmable timeout, the block raises that engine's sticky stall flag. If recovery is armed, it also emits a one-cycle request that puts the controller into reset.

All four monitors run on one shared coarse time base. A prescaler divides the transmit clock, and each timeout counts periods of that time base. Both DMA monitors use one timeout limit. Both MAC monitors use a second, independent limit. Configuration arrives through two write strobes. One loads the monitor enables and the recovery arm bit. The other loads the prescaler period and both timeout limits, and restarts all timing.

Top module: `lockup_watchdog`

## Requirements
- R1: After reset all stall flags and the reset request are low, and every monitor enable and the recovery arm bit are cleared, so no flag rises while engines are busy until an enable is written.
- R2: A monitor whose enable is clear never shows a flag; clearing an enable drops that engine's flag on the following cycle.
- R3: With prescaler value P and DMA limit L > 0, a DMA engine (index 0 = transmit DMA, index 2 = receive DMA) that stays busy without progress from a timing write onward shows its flag exactly L*(P+1)+1 clock edges after that write, and not one edge sooner.
- R4: The MAC engines (index 1 = transmit MAC, index 3 = receive MAC) follow the same timing using the MAC limit, independent of the DMA limit.
- R5: A progress strobe clears the engine's elapsed-time count, so timing restarts from the strobe.
- R6: A cycle with busy low clears the engine's elapsed-time count in the same way.
- R7: A limit of zero disables detection for the engines of that group.
- R8: A stall flag stays set after the engine goes idle, until a software clear bit for that engine, a recovery request, or a cleared enable removes it.
- R9: With recovery armed, a new stall produces a reset request one cycle wide on the same edge the flag rises; the next edge clears all flags and counts.
- R10: With recovery not armed, no reset request is ever produced.
- R11: No reset request is produced while any stall flag was already set in the previous cycle.
- R12: A timing write restarts the prescaler and every elapsed-time count.
- R13: Out of reset the prescaler period, DMA limit and MAC limit take their parameterised reset values (0xFFFF, 0x7FF, 0x7FF by default) and are used without any timing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en_wr | input | 1 | Load strobe for enables and recovery arm bit |
| cfg_en_val | input | 4 | Per-engine monitor enables (bit order as in R3/R4) |
| cfg_recov_val | input | 1 | Recovery arm value |
| cfg_time_wr | input | 1 | Load strobe for prescaler and limits; restarts timing |
| cfg_prescale | input | PRE_W | Prescaler value P (period P+1 clocks) |
| cfg_dma_lim | input | DMA_W | DMA group limit in prescaler periods |
| cfg_mac_lim | input | MAC_W | MAC group limit in prescaler periods |
| eng_busy | input | 4 | Per-engine busy level |
| eng_progress | input | 4 | Per-engine progress strobe |
| flag_clr | input | 4 | Per-engine software flag clear |
| lockup | output | 4 | Per-engine sticky stall flags |
| reset_req | output | 1 | One-cycle controller reset request |

## Verification
The bench sweeps prescaler values 0 to 3 against limits 1 to 3 for both groups and checks the flag exactly at its expected edge and one edge earlier. An off-by-one in the prescaler reload or in the compare would show up as a flag one period early or late. Single-cycle progress strobes, idle gaps and mid-count timing writes probe the restart paths; a design that ignored any of them would flag at the original, earlier edge. The recovery cases check the request width and the clearing of flags. They also check that a second stall raises no request while an older flag is still pending, which catches a request generated from a level instead of from a new event.

// File: rtl/lw_pkg.sv
package lw_pkg;
  localparam int unsigned NUM_ENG = 4;

  // engines at odd indices are MAC engines, even indices are DMA engines
  function automatic bit is_mac_eng(input int unsigned idx);
    return (idx % 2) == 1;
  endfunction
endpackage

// File: rtl/lw_cfg_regs.sv
module lw_cfg_regs #(
  parameter int unsigned NE    = 4,
  parameter int unsigned PRE_W = 16,
  parameter int unsigned DMA_W = 11,
  parameter int unsigned MAC_W = 11,
  parameter logic [PRE_W-1:0] PRE_RST = '1,
  parameter logic [DMA_W-1:0] DMA_RST = '1,
  parameter logic [MAC_W-1:0] MAC_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [NE-1:0]    en_val,
  input  logic             recov_val,
  input  logic             time_wr,
  input  logic [PRE_W-1:0] pre_val,
  input  logic [DMA_W-1:0] dma_val,
  input  logic [MAC_W-1:0] mac_val,
  output logic [NE-1:0]    en_q,
  output logic             recov_q,
  output logic [PRE_W-1:0] pre_q,
  output logic [DMA_W-1:0] dma_q,
  output logic [MAC_W-1:0] mac_q
);
  logic [NE-1:0]    en_d;
  logic             recov_d;
  logic [PRE_W-1:0] pre_d;
  logic [DMA_W-1:0] dma_d;
  logic [MAC_W-1:0] mac_d;

  always_comb begin
    en_d    = en_q;
    recov_d = recov_q;
    pre_d   = pre_q;
    dma_d   = dma_q;
    mac_d   = mac_q;
    if (en_wr) begin
      en_d    = en_val;
      recov_d = recov_val;
    end
    if (time_wr) begin
      pre_d = pre_val;
      dma_d = dma_val;
      mac_d = mac_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      recov_q <= 1'b0;
      pre_q   <= PRE_RST;
      dma_q   <= DMA_RST;
      mac_q   <= MAC_RST;
    end else begin
      en_q    <= en_d;
      recov_q <= recov_d;
      pre_q   <= pre_d;
      dma_q   <= dma_d;
      mac_q   <= mac_d;
    end
  end
endmodule

// File: rtl/lw_prescaler.sv
module lw_prescaler #(
  parameter int unsigned PRE_W = 16,
  parameter logic [PRE_W-1:0] PRE_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] reload_new,
  input  logic [PRE_W-1:0] reload_cur,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;

  assign tick = (pcnt_q == '0);

  always_comb begin
    if (restart)   pcnt_d = reload_new;
    else if (tick) pcnt_d = reload_cur;
    else           pcnt_d = pcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= PRE_RST;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/lw_stall_mon.sv
module lw_stall_mon #(
  parameter int unsigned CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          busy,
  input  logic          progress,
  input  logic          tick,
  input  logic          restart,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          flag,
  output logic          set_now
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_d;
  logic          hit;
  logic          hold_zero;
  logic          cnt_ce;

  assign hold_zero = !en || !busy || progress || restart || clr;
  assign cnt_ce    = tick && (cnt_q != limit);
  assign hit       = en && (limit != '0) && (cnt_q == limit);
  assign set_now   = hit && !flag && !clr;

  always_comb begin
    if (hold_zero)   cnt_d = '0;
    else if (cnt_ce) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_comb begin
    if (clr || !en) flag_d = 1'b0;
    else if (hit)   flag_d = 1'b1;
    else            flag_d = flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flag  <= flag_d;
    end
  end
endmodule

// File: rtl/lockup_watchdog.sv
module lockup_watchdog
  import lw_pkg::*;
#(
  parameter int unsigned PRE_W = 16,
  parameter int unsigned DMA_W = 11,
  parameter int unsigned MAC_W = 11,
  parameter logic [PRE_W-1:0] PRE_RST = '1,
  parameter logic [DMA_W-1:0] DMA_RST = '1,
  parameter logic [MAC_W-1:0] MAC_RST = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en_wr,
  input  logic [NUM_ENG-1:0] cfg_en_val,
  input  logic               cfg_recov_val,
  input  logic               cfg_time_wr,
  input  logic [PRE_W-1:0]   cfg_prescale,
  input  logic [DMA_W-1:0]   cfg_dma_lim,
  input  logic [MAC_W-1:0]   cfg_mac_lim,
  input  logic [NUM_ENG-1:0] eng_busy,
  input  logic [NUM_ENG-1:0] eng_progress,
  input  logic [NUM_ENG-1:0] flag_clr,
  output logic [NUM_ENG-1:0] lockup,
  output logic               reset_req
);
  localparam int unsigned CW = (DMA_W > MAC_W) ? DMA_W : MAC_W;

  logic [NUM_ENG-1:0] en_q;
  logic               recov_q;
  logic [PRE_W-1:0]   pre_q;
  logic [DMA_W-1:0]   dma_q;
  logic [MAC_W-1:0]   mac_q;
  logic               tick;
  logic [NUM_ENG-1:0] set_vec;
  logic [NUM_ENG-1:0] clr_vec;
  logic               reset_req_d;

  lw_cfg_regs #(
    .NE(NUM_ENG), .PRE_W(PRE_W), .DMA_W(DMA_W), .MAC_W(MAC_W),
    .PRE_RST(PRE_RST), .DMA_RST(DMA_RST), .MAC_RST(MAC_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .en_wr(cfg_en_wr), .en_val(cfg_en_val), .recov_val(cfg_recov_val),
    .time_wr(cfg_time_wr), .pre_val(cfg_prescale),
    .dma_val(cfg_dma_lim), .mac_val(cfg_mac_lim),
    .en_q(en_q), .recov_q(recov_q), .pre_q(pre_q), .dma_q(dma_q), .mac_q(mac_q)
  );

  lw_prescaler #(.PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(cfg_time_wr),
    .reload_new(cfg_prescale), .reload_cur(pre_q), .tick(tick)
  );

  assign clr_vec = flag_clr | {NUM_ENG{reset_req}};

  for (genvar gi = 0; gi < NUM_ENG; gi++) begin : g_mon
    logic [CW-1:0] lim;
    if (is_mac_eng(gi)) begin : g_mac
      assign lim = CW'(mac_q);
    end else begin : g_dma
      assign lim = CW'(dma_q);
    end
    lw_stall_mon #(.CW(CW)) u_mon (
      .clk(clk), .rst_n(rst_n), .en(en_q[gi]), .busy(eng_busy[gi]),
      .progress(eng_progress[gi]), .tick(tick), .restart(cfg_time_wr),
      .clr(clr_vec[gi]), .limit(lim), .flag(lockup[gi]), .set_now(set_vec[gi])
    );
  end

  // request only on a fresh stall, and only when no older flag is pending
  assign reset_req_d = recov_q && (|set_vec) && !(|lockup);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= reset_req_d;
  end
endmodule

// File: rtl/lockup_watchdog_chk.sv
module lockup_watchdog_chk #(
  parameter int unsigned NE    = 4,
  parameter int unsigned DMA_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NE-1:0]    en_q,
  input logic [NE-1:0]    lockup,
  input logic [NE-1:0]    flag_clr,
  input logic             recov_q,
  input logic             reset_req,
  input logic [DMA_W-1:0] dma_q
);
  // R9
  req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R10
  req_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(recov_q));

  // R11
  req_only_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> ($past(lockup) == '0));

  // R2
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lockup & ~$past(en_q)) == '0));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(lockup) & ~lockup & ~$past(flag_clr) & $past(en_q))) |-> $past(reset_req));

  // R7
  zero_limit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockup[0]) |-> (dma_q != '0));
endmodule

bind lockup_watchdog lockup_watchdog_chk #(.DMA_W(DMA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .lockup(lockup), .flag_clr(flag_clr),
  .recov_q(recov_q), .reset_req(reset_req), .dma_q(dma_q)
);

// File: tb/lockup_watchdog_test.sv
`timescale 1ns/1ps
module lockup_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en_wr, cfg_recov_val, cfg_time_wr;
  logic [3:0]  cfg_en_val;
  logic [15:0] cfg_prescale;
  logic [10:0] cfg_dma_lim, cfg_mac_lim;
  logic [3:0]  eng_busy, eng_progress, flag_clr;
  logic [3:0]  lockup;
  logic        reset_req;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  lockup_watchdog #(
    .PRE_RST(16'd3), .DMA_RST(11'd2), .MAC_RST(11'd5)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_en_wr(cfg_en_wr), .cfg_en_val(cfg_en_val), .cfg_recov_val(cfg_recov_val),
    .cfg_time_wr(cfg_time_wr), .cfg_prescale(cfg_prescale),
    .cfg_dma_lim(cfg_dma_lim), .cfg_mac_lim(cfg_mac_lim),
    .eng_busy(eng_busy), .eng_progress(eng_progress), .flag_clr(flag_clr),
    .lockup(lockup), .reset_req(reset_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_en(input logic [3:0] e, input logic r);
    cfg_en_val = e; cfg_recov_val = r; cfg_en_wr = 1'b1;
    adv(1);
    cfg_en_wr = 1'b0;
  endtask

  task automatic do_time(input int p, input int d, input int m);
    cfg_prescale = 16'(p); cfg_dma_lim = 11'(d); cfg_mac_lim = 11'(m);
    cfg_time_wr = 1'b1;
    adv(1);
    cfg_time_wr = 1'b0;
  endtask

  task automatic cleanup();
    eng_busy = 4'h0; eng_progress = 4'h0; flag_clr = 4'hF;
    adv(1);
    flag_clr = 4'h0;
    adv(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    rst_n = 1'b0;
    cfg_en_wr = 0; cfg_recov_val = 0; cfg_time_wr = 0; cfg_en_val = 0;
    cfg_prescale = 0; cfg_dma_lim = 0; cfg_mac_lim = 0;
    eng_busy = 0; eng_progress = 0; flag_clr = 0;
    adv(3);
    rst_n = 1'b1;
    adv(1);

    // R1: reset state, and nothing enabled after reset
    chk(lockup == 4'h0, "R1 flags", lockup, 0);
    chk(reset_req == 1'b0, "R1 request", reset_req, 0);
    eng_busy = 4'hF;
    adv(40);
    chk(lockup == 4'h0, "R1 enables cleared", lockup, 0);

    // R13: reset-valued prescaler (3) and DMA limit (2), no timing write
    do_en(4'b0001, 1'b0);
    adv(5);
    chk(lockup == 4'h0, "R13 early", lockup, 0);
    adv(4);
    chk(lockup == 4'b0001, "R13 reset limits used", lockup, 1);
    cleanup();
    do_en(4'b0000, 1'b0);

    // R3 / R4 sweep: exact flag edge for both groups
    for (int g = 0; g < 2; g++) begin
      logic [3:0] en;
      en = (g == 0) ? 4'b0101 : 4'b1010;
      do_en(en, 1'b0);
      for (int p = 0; p < 4; p++) begin
        for (int l = 1; l < 4; l++) begin
          eng_busy = en;
          if (g == 0) do_time(p, l, l + 1);
          else        do_time(p, l + 2, l);
          adv(l * (p + 1));
          chk(lockup == 4'h0, (g == 0) ? "R3 not early" : "R4 not early", lockup, 0);
          adv(1);
          chk(lockup == en, (g == 0) ? "R3 on time" : "R4 on time", lockup, en);
          chk(reset_req == 1'b0, "R10 unarmed", reset_req, 0);
          cleanup();
        end
      end
    end

    // R7: zero DMA limit never flags
    do_en(4'b0101, 1'b0);
    eng_busy = 4'b0101;
    do_time(0, 0, 1);
    adv(30);
    chk(lockup == 4'h0, "R7 zero limit", lockup, 0);
    cleanup();

    // R5: progress strobe restarts the count
    do_en(4'b0001, 1'b0);
    eng_busy = 4'b0001;
    do_time(1, 3, 0);
    adv(2);
    eng_progress = 4'b0001;
    adv(1);
    eng_progress = 4'b0000;
    adv(5);
    chk(lockup == 4'h0, "R5 delayed", lockup, 0);
    adv(1);
    chk(lockup == 4'b0001, "R5 flag", lockup, 1);
    cleanup();

    // R6: idle cycle restarts the count
    eng_busy = 4'b0001;
    do_time(1, 3, 0);
    adv(2);
    eng_busy = 4'b0000;
    adv(1);
    eng_busy = 4'b0001;
    adv(5);
    chk(lockup == 4'h0, "R6 delayed", lockup, 0);
    adv(1);
    chk(lockup == 4'b0001, "R6 flag", lockup, 1);
    cleanup();

    // R12: timing write restarts everything
    eng_busy = 4'b0001;
    do_time(1, 3, 0);
    adv(5);
    do_time(1, 3, 0);
    adv(1);
    chk(lockup == 4'h0, "R12 old deadline", lockup, 0);
    adv(5);
    chk(lockup == 4'h0, "R12 not early", lockup, 0);
    adv(1);
    chk(lockup == 4'b0001, "R12 flag", lockup, 1);
    cleanup();

    // R8: sticky until software clear
    eng_busy = 4'b0001;
    do_time(0, 2, 0);
    adv(3);
    chk(lockup == 4'b0001, "R8 set", lockup, 1);
    eng_busy = 4'b0000;
    adv(5);
    chk(lockup == 4'b0001, "R8 held", lockup, 1);
    flag_clr = 4'b0001;
    adv(1);
    flag_clr = 4'b0000;
    chk(lockup == 4'h0, "R8 cleared", lockup, 0);
    cleanup();

    // R2: only enabled engines flag; disabling drops the flag
    do_en(4'b0001, 1'b0);
    eng_busy = 4'hF;
    do_time(0, 1, 1);
    adv(10);
    chk(lockup == 4'b0001, "R2 enabled only", lockup, 1);
    do_en(4'b0000, 1'b0);
    adv(1);
    chk(lockup == 4'h0, "R2 disable drops", lockup, 0);
    cleanup();

    // R9: recovery pulse, clearing, and repeat
    do_en(4'b0001, 1'b1);
    eng_busy = 4'b0001;
    do_time(0, 2, 0);
    adv(2);
    chk(reset_req == 1'b0, "R9 idle", reset_req, 0);
    adv(1);
    chk(lockup == 4'b0001, "R9 flag", lockup, 1);
    chk(reset_req == 1'b1, "R9 pulse", reset_req, 1);
    adv(1);
    chk(reset_req == 1'b0, "R9 width", reset_req, 0);
    chk(lockup == 4'h0, "R9 flags cleared", lockup, 0);
    adv(3);
    chk(reset_req == 1'b1, "R9 second pulse", reset_req, 1);
    cleanup();
    do_en(4'b0000, 1'b0);

    // R11: no request while an older flag is pending
    do_en(4'b0101, 1'b0);
    eng_busy = 4'b0001;
    do_time(0, 2, 0);
    adv(3);
    chk(lockup == 4'b0001, "R11 first flag", lockup, 1);
    eng_busy = 4'b0101;
    do_en(4'b0101, 1'b1);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      adv(1);
      if (reset_req) cnt++;
    end
    chk(cnt == 0, "R11 no request", cnt, 0);
    chk(lockup == 4'b0101, "R11 second flag", lockup, 5);
    cleanup();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule